// File: doc/BRIEF.md
# Upper-Memory Shadow Routing Decoder

This block sits between the processor's memory cycles and the memory controller. It decides, for each access that lands in the upper-memory window from 0xC0000 to 0xFFFFF, whether the cycle is served from on-board DRAM or forwarded to the expansion bus. Reads and writes are steered independently. This independence lets firmware copy a ROM image into the DRAM underneath it: reads still come from the bus while writes fill the DRAM, and the DRAM copy is switched to serve reads afterwards.

Three shadow control registers hold the steering bits. They are written through an I/O index/data pair. A byte written to port 0x22 selects a register. A byte written to port 0x24 stores into the selected register. The area from 0xC0000 to 0xDFFFF is steered in eight 16 KB chunks, held in two registers. The two 64 KB segments at 0xE0000 and 0xF0000 share a third register with coarser control.

A mode input restricts the decision to processor-originated cycles. In that mode, accesses from other bus masters are always forwarded to the bus. The routing decision for an access appears on the outputs one clock after the access is presented.

Top module: `shadow_region_decoder`

## Requirements
- R1: After synchronous reset, both outputs are low and all shadow registers and the index read as zero. Every access in the window is therefore routed to the bus until software writes a register.
- R2: A write to I/O address 0x22 loads the index. A write to 0x24 stores the byte into the register the index selects. Writes to any other I/O address have no effect on routing. Data writes while the index holds a value other than 0x04, 0x05 or 0x06 also have no effect on routing.
- R3: Register 0x06 steers the two upper segments. Bit 0 is the read enable and bit 1 the write enable for 0xE0000–0xEFFFF. Bit 2 is the read enable and bit 3 the write enable for 0xF0000–0xFFFFF. Bits 7:4 have no effect.
- R4: Registers 0x04 and 0x05 steer 16 KB chunks. Index bit 0 picks the 64 KB half. Chunk i of a register starts at 0xC0000 + (index[0] << 16) + (i << 14). Its read enable is bit 2i and its write enable is bit 2i+1.
- R5: A set enable for the access type raises dram_sel, and a clear enable raises bus_fwd. Either output rises one clock after the access. Read and write enables act independently: with write enabled and read disabled, reads go to the bus and writes go to DRAM.
- R6: An access below 0xC0000 raises neither output.
- R7: With cpu_only_mode high, an in-window access whose acc_from_cpu is low always raises bus_fwd. With cpu_only_mode low, every master is routed by the enable bits.
- R8: A register write takes effect for accesses presented in the following cycle. An access presented in the same cycle as the write is routed by the previous setting.
- R9: A cycle without acc_valid leaves both outputs low in the next cycle.
- R10: dram_sel and bus_fwd are never high together. Exactly one of them is high after every valid in-window access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O write address |
| io_wdata | input | 8 | I/O write data |
| acc_valid | input | 1 | Memory access present this cycle |
| acc_addr | input | 20 | Memory access address |
| acc_write | input | 1 | Access is a write (1) or a read (0) |
| acc_from_cpu | input | 1 | Access was issued by the processor |
| cpu_only_mode | input | 1 | Restrict shadow decision to processor cycles |
| dram_sel | output | 1 | Access is served from on-board DRAM |
| bus_fwd | output | 1 | Access is forwarded to the expansion bus |

## Verification
Two functions can coincide in one cycle: a data-port write that changes a shadow register, and a memory access to the very region that register governs. The bench provokes this directly. It writes a new value for the 0xF0000 segment in the same cycle as a read of that segment, then repeats the read one cycle later. Its reference model routes the first read by the old register value and the second by the new one. Randomised traffic then mixes index, data and foreign-port writes with accesses from both master types on every clock, and each output pair is compared with the model.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    localparam int SYS_AW         = 20;
    localparam int CTRL_W         = 8;
    localparam int CHUNK_SHIFT    = 14;
    localparam int SEG_SHIFT      = 16;
    localparam int NUM_LOW        = 8;
    localparam int NUM_TOP        = 2;
    localparam int NUM_REGIONS    = NUM_LOW + NUM_TOP;
    localparam int REGION_W       = $clog2(NUM_REGIONS);
    localparam int CHUNKS_PER_REG = CTRL_W / 2;
    localparam int TOP_W          = 2 * NUM_TOP;

    localparam logic [SYS_AW-1:0] WIN_BASE = 20'hC0000;
    localparam logic [SYS_AW-1:0] LOW_SPAN = SYS_AW'(NUM_LOW) << CHUNK_SHIFT;

    typedef struct packed {
        logic [TOP_W-1:0]  top;
        logic [CTRL_W-1:0] high;
        logic [CTRL_W-1:0] low;
    } shadow_cfg_t;

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'd0,
        ROUTE_DRAM = 2'd1,
        ROUTE_BUS  = 2'd2
    } route_e;

    function automatic logic addr_in_window(input logic [SYS_AW-1:0] a);
        return a >= WIN_BASE;
    endfunction

    function automatic logic [REGION_W-1:0] region_of(input logic [SYS_AW-1:0] a);
        logic [SYS_AW-1:0] off;
        off = a - WIN_BASE;
        if (off < LOW_SPAN)
            return REGION_W'(off >> CHUNK_SHIFT);
        else
            return REGION_W'(NUM_LOW) + REGION_W'((off - LOW_SPAN) >> SEG_SHIFT);
    endfunction

endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
    import shadow_pkg::*;
#(
    parameter int                 IO_AW     = 16,
    parameter logic [IO_AW-1:0]   IDX_PORT  = 16'h0022,
    parameter logic [IO_AW-1:0]   DATA_PORT = 16'h0024,
    parameter logic [CTRL_W-1:0]  IDX_LOW   = 8'h04,
    parameter logic [CTRL_W-1:0]  IDX_TOP   = 8'h06
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [CTRL_W-1:0] io_wdata,
    output shadow_cfg_t       cfg
);

    localparam logic [CTRL_W-1:0] IDX_HIGH = IDX_LOW | CTRL_W'(1);

    logic [CTRL_W-1:0] idx_q;
    shadow_cfg_t       cfg_q;
    logic              idx_wr;
    logic              data_wr;

    assign idx_wr  = io_wr && (io_addr == IDX_PORT);
    assign data_wr = io_wr && (io_addr == DATA_PORT);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (idx_wr) begin
            idx_q <= io_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (data_wr) begin
            if (idx_q == IDX_LOW)
                cfg_q.low <= io_wdata;
            if (idx_q == IDX_HIGH)
                cfg_q.high <= io_wdata;
            if (idx_q == IDX_TOP)
                cfg_q.top <= io_wdata[TOP_W-1:0];
        end
    end

    assign cfg = cfg_q;

    AST_FOREIGN_PORT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr != IDX_PORT && io_addr != DATA_PORT) |=> $stable(cfg_q)); // R2

    AST_UNMAPPED_INDEX_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (data_wr && idx_q != IDX_LOW && idx_q != IDX_HIGH && idx_q != IDX_TOP)
        |=> $stable(cfg_q)); // R2

endmodule

// File: rtl/shadow_region_lookup.sv
module shadow_region_lookup
    import shadow_pkg::*;
(
    input  shadow_cfg_t       cfg,
    input  logic [SYS_AW-1:0] addr,
    input  logic              is_write,
    output logic              in_window,
    output logic              dram_enable
);

    logic [NUM_REGIONS-1:0] rd_en;
    logic [NUM_REGIONS-1:0] wr_en;
    logic [REGION_W-1:0]    region;

    for (genvar i = 0; i < NUM_LOW; i++) begin : g_low_chunk
        localparam int HALF = i / CHUNKS_PER_REG;
        localparam int SUB  = i % CHUNKS_PER_REG;
        if (HALF == 0) begin : g_first
            assign rd_en[i] = cfg.low[2*SUB];
            assign wr_en[i] = cfg.low[2*SUB+1];
        end else begin : g_second
            assign rd_en[i] = cfg.high[2*SUB];
            assign wr_en[i] = cfg.high[2*SUB+1];
        end
    end

    for (genvar j = 0; j < NUM_TOP; j++) begin : g_top_seg
        assign rd_en[NUM_LOW+j] = cfg.top[2*j];
        assign wr_en[NUM_LOW+j] = cfg.top[2*j+1];
    end

    always_comb begin
        in_window   = addr_in_window(addr);
        region      = region_of(addr);
        dram_enable = 1'b0;
        if (in_window)
            dram_enable = is_write ? wr_en[region] : rd_en[region];
    end

endmodule

// File: rtl/shadow_route_out.sv
module shadow_route_out
    import shadow_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic acc_valid,
    input  logic in_window,
    input  logic dram_enable,
    input  logic from_cpu,
    input  logic cpu_only,
    output logic dram_sel,
    output logic bus_fwd
);

    route_e route_q;
    route_e route_d;

    always_comb begin
        if (!acc_valid || !in_window)
            route_d = ROUTE_NONE;
        else if (cpu_only && !from_cpu)
            route_d = ROUTE_BUS;
        else if (dram_enable)
            route_d = ROUTE_DRAM;
        else
            route_d = ROUTE_BUS;
    end

    always_ff @(posedge clk) begin
        if (rst)
            route_q <= ROUTE_NONE;
        else
            route_q <= route_d;
    end

    assign dram_sel = (route_q == ROUTE_DRAM);
    assign bus_fwd  = (route_q == ROUTE_BUS);

    AST_ROUTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dram_sel, bus_fwd})); // R10

    AST_WINDOW_ROUTED: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && in_window) |=> (dram_sel || bus_fwd)); // R10

    AST_OUTSIDE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !in_window) |=> (!dram_sel && !bus_fwd)); // R6

    AST_MASTER_FILTER: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && in_window && cpu_only && !from_cpu) |=> bus_fwd); // R7

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!dram_sel && !bus_fwd)); // R9

endmodule

// File: rtl/shadow_region_decoder.sv
module shadow_region_decoder
    import shadow_pkg::*;
#(
    parameter int                IO_AW     = 16,
    parameter logic [IO_AW-1:0]  IDX_PORT  = 16'h0022,
    parameter logic [IO_AW-1:0]  DATA_PORT = 16'h0024,
    parameter logic [CTRL_W-1:0] IDX_LOW   = 8'h04,
    parameter logic [CTRL_W-1:0] IDX_TOP   = 8'h06
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [CTRL_W-1:0] io_wdata,
    input  logic              acc_valid,
    input  logic [SYS_AW-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_from_cpu,
    input  logic              cpu_only_mode,
    output logic              dram_sel,
    output logic              bus_fwd
);

    shadow_cfg_t cfg;
    logic        in_window;
    logic        dram_enable;

    shadow_cfg_regs #(
        .IO_AW     (IO_AW),
        .IDX_PORT  (IDX_PORT),
        .DATA_PORT (DATA_PORT),
        .IDX_LOW   (IDX_LOW),
        .IDX_TOP   (IDX_TOP)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .cfg      (cfg)
    );

    shadow_region_lookup u_lookup (
        .cfg         (cfg),
        .addr        (acc_addr),
        .is_write    (acc_write),
        .in_window   (in_window),
        .dram_enable (dram_enable)
    );

    shadow_route_out u_route (
        .clk         (clk),
        .rst         (rst),
        .acc_valid   (acc_valid),
        .in_window   (in_window),
        .dram_enable (dram_enable),
        .from_cpu    (acc_from_cpu),
        .cpu_only    (cpu_only_mode),
        .dram_sel    (dram_sel),
        .bus_fwd     (bus_fwd)
    );

endmodule

// File: tb/shadow_region_decoder_test.sv
`timescale 1ns/1ps
module shadow_region_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [19:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        acc_from_cpu = 1'b1;
    logic        cpu_only_mode = 1'b0;
    logic        dram_sel;
    logic        bus_fwd;

    always #2.5 clk = ~clk;

    shadow_region_decoder uut (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
        .acc_from_cpu(acc_from_cpu), .cpu_only_mode(cpu_only_mode),
        .dram_sel(dram_sel), .bus_fwd(bus_fwd)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    // reference model state
    int    m_idx = 0;
    int    m_low = 0;
    int    m_high = 0;
    int    m_top = 0;

    bit    exp_dram = 0;
    bit    exp_bus  = 0;
    string exp_tag  = "R1";
    string force_tag = "";

    task automatic compare();
        checks++;
        if (dram_sel !== exp_dram || bus_fwd !== exp_bus) begin
            fails++;
            $display("FAIL %s: dram_sel/bus_fwd = %b/%b, expected %b/%b at %0t",
                     exp_tag, dram_sel, bus_fwd, exp_dram, exp_bus, $time);
        end
        checks++;
        if (dram_sel === 1'b1 && bus_fwd === 1'b1) begin // R10
            fails++;
            $display("FAIL R10: both outputs high, expected at most one at %0t", $time);
        end
    endtask

    // One cycle: compare last expectation, drive new inputs, predict.
    task automatic step(input bit wr, input int port, input int data,
                        input bit v, input int a, input bit w, input bit cpu, input bit mode);
        int off, chunk, seg, regv, b;
        @(negedge clk);
        compare();
        io_wr = wr; io_addr = 16'(port); io_wdata = 8'(data);
        acc_valid = v; acc_addr = 20'(a); acc_write = w;
        acc_from_cpu = cpu; cpu_only_mode = mode;
        exp_dram = 0; exp_bus = 0;
        if (!v) exp_tag = "R9";
        else if (a < 'hC0000) exp_tag = "R6";
        else if (mode && !cpu) begin exp_tag = "R7"; exp_bus = 1; end
        else begin
            off = a - 'hC0000;
            if (off < 'h20000) begin
                chunk = off / 'h4000;
                regv = (chunk < 4) ? m_low : m_high;
                b = 2 * (chunk % 4) + int'(w);
                exp_tag = "R4";
            end else begin
                seg = (off - 'h20000) / 'h10000;
                regv = m_top & 'h0F;
                b = 2 * seg + int'(w);
                exp_tag = "R3";
            end
            if ((regv >> b) & 1) exp_dram = 1; else exp_bus = 1;
        end
        if (force_tag != "") exp_tag = force_tag;
        // register update after the prediction: same-cycle access sees old state (R8)
        if (wr) begin
            if (port == 'h22) m_idx = data & 'hFF;
            else if (port == 'h24) begin
                if (m_idx == 4) m_low = data & 'hFF;
                else if (m_idx == 5) m_high = data & 'hFF;
                else if (m_idx == 6) m_top = data & 'hFF;
            end
        end
    endtask

    task automatic acc(input int a, input bit w);
        step(0, 0, 0, 1, a, w, 1, 0);
    endtask

    task automatic wreg(input int idx, input int data);
        step(1, 'h22, idx, 0, 0, 0, 1, 0);
        step(1, 'h24, data, 0, 0, 0, 1, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (dram_sel !== 0 || bus_fwd !== 0) begin
            fails++;
            $display("FAIL R1: in reset dram_sel/bus_fwd = %b/%b, expected 0/0", dram_sel, bus_fwd);
        end
        rst = 0;

        // R1: everything routes to the bus after reset
        force_tag = "R1";
        for (int i = 0; i < 10; i++) begin
            acc('hC0000 + i * 'h4000 + (i < 8 ? 0 : (i - 8) * 'hC000), i[0]);
        end

        // R3: top register, each bit alone, bits 7:4 ignored
        force_tag = "R3";
        wreg(6, 'hF1);
        acc('hE0000, 0); acc('hE8000, 1); acc('hF0000, 0); acc('hFFFFF, 1);
        wreg(6, 'h0A);
        acc('hEFFFF, 0); acc('hE4000, 1); acc('hF1234, 0); acc('hF0000, 1);

        // R2: foreign port and unmapped index writes change nothing
        force_tag = "R2";
        step(1, 'h23, 'h00, 1, 'hF0000, 1, 1, 0);
        acc('hF0000, 1);
        wreg(7, 'h00);
        acc('hF0000, 1); acc('hE0000, 1);
        step(1, 'h0024, 'h55, 0, 0, 0, 1, 0);
        acc('hF0000, 1);

        // R4: chunk sweep of both halves
        force_tag = "R4";
        wreg(4, 'b10_01_11_01);
        wreg(5, 'b01_00_10_11);
        for (int i = 0; i < 8; i++) begin
            acc('hC0000 + i * 'h4000 + 'h123, 0);
            acc('hC0000 + i * 'h4000 + 'h3FFF, 1);
        end

        // R5: write-only shadow for ROM copy
        force_tag = "R5";
        wreg(4, 'hAA);
        acc('hC0000, 0); acc('hC0000, 1); acc('hCC000, 0); acc('hCC000, 1);

        // R8: register write and access to the same segment in one cycle
        force_tag = "R8";
        wreg(6, 'h04);
        step(1, 'h22, 6, 0, 0, 0, 1, 0);
        step(1, 'h24, 'h00, 1, 'hF0000, 0, 1, 0);
        acc('hF0000, 0);
        step(1, 'h24, 'h04, 1, 'hF8000, 0, 1, 0);
        acc('hF8000, 0);

        // R7: master filter
        force_tag = "R7";
        step(0, 0, 0, 1, 'hF0000, 0, 0, 1);
        step(0, 0, 0, 1, 'hF0000, 0, 1, 1);
        step(0, 0, 0, 1, 'hF0000, 0, 0, 0);
        step(0, 0, 0, 1, 'hC4000, 1, 0, 1);

        // R6 / R9: outside and idle
        force_tag = "";
        acc('h00000, 0); acc('hBFFFF, 1); acc('hA0000, 0);
        step(0, 0, 0, 0, 'hF0000, 0, 1, 0);
        step(0, 0, 0, 0, 'hC0000, 1, 1, 1);

        // mixed traffic on every clock
        for (int n = 0; n < 3000; n++) begin
            int sel, port, data, a;
            sel = $urandom_range(0, 9);
            port = (sel < 2) ? 'h22 : (sel < 4) ? 'h24 : (sel == 4) ? 'h23 : 'h80;
            data = (port == 'h22) ? $urandom_range(3, 7) : $urandom_range(0, 255);
            a = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 'hBFFFF)
                                             : 'hC0000 + $urandom_range(0, 'h3FFFF);
            step(sel < 5, port, data, $urandom_range(0, 5) != 0, a,
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        step(0, 0, 0, 0, 0, 0, 1, 0);
        @(negedge clk);
        compare();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule